// File: doc/BRIEF.md
# Multi-Bank Memory and Peripheral Bus Controller

This block turns word-addressed CPU requests into the strobe sequence of an external asynchronous bus holding up to six banks of flash, SRAM, dual-port memory or peripheral devices. Every bank carries its own configuration: an enable, a port width of 8, 16 or 32 bits, an access style and a count of wait states. A request names a word address, byte enables, a direction, whether a DMA engine issued it, a burst length of one to four words and a burst ordering. The controller selects the bank, drives the active-low chip select, output enable and per-lane write enables, and presents the byte address inside the bank, low bits included.

A word wider than the bank's port is carried as a series of narrow accesses, one per port-sized slice of the word, with the write enables moved onto the port's lanes. An active-low wait input holds the final cycle of an access in the normal and I/O styles. In the dual-port style it aborts the attempt and the access is retried from the start. Two further outputs steer an external data transceiver: an output enable for every bank access, and a direction with its own drive enable, which is driven only for DMA accesses.

Configuration is written through a one-cycle write port: a 3-bit bank index and a 9-bit word laid out as {enable[8], style[7:6], width[5:4], waits[3:0]}.

Top module: `mem_bus_ctrl`

## Requirements
- R1: The bank is word-address bits [23:21]. During an access only the chip select of that bank is low, and at no time is more than one chip select low.
- R2: A request to a disabled bank or to bank index 6 or 7 starts no access. `err` is high for the single cycle after the request is taken, and `busy` stays low.
- R3: A bank programmed with W wait states holds each access for W+1 cycles when `bus_wait_n` stays high. `ack` is high in the last of those cycles.
- R4: In styles 0 (memory), 1 (split-strobe I/O) and 2 (single-strobe I/O), `bus_wait_n` low in the last cycle holds that cycle for one more clock. Low earlier in the access has no effect.
- R5: In style 3 (dual-port), `bus_wait_n` low in the last cycle releases the chip select for one cycle. The access then repeats in full with W wait states, and no `ack` is given for the aborted attempt.
- R6: `bus_addr` is the byte address inside the bank. Bits [22:4] are word-address bits [20:2] and bits [3:2] are the burst word index. Bits [1:0] are the lane index for an 8-bit port (width code 0), {slice,0} for a 16-bit port (width code 1), and 00 for a 32-bit port (width code 2).
- R7: An 8-bit port takes four accesses per word, lanes 0 to 3 in turn. A 16-bit port takes two, the low half then the high half. On a write, only `we_n[0]` (8-bit) or `we_n[1:0]` (16-bit) can go low, and each follows the byte enable of the slice being carried. A 32-bit write drives `we_n` as the inverted byte enables. On a read, `we_n` stays 4'hF.
- R8: A burst of N words (`req_beats` = N-1) starts at word index `req_waddr[1:0]`. It advances by +1 modulo 4 when `req_sub` is 0 and by XOR with the beat count when `req_sub` is 1.
- R9: `oe_n` is low during read accesses. In style 2 it is also low during writes, as a data strobe.
- R10: `xcvr_oe_n` is low during every access. `xcvr_dir_en` is high only during DMA accesses, and then `xcvr_dir_n` is low for reads and high for writes. `xcvr_dir_n` is high whenever `xcvr_dir_en` is low.
- R11: After reset every bank is disabled, all chip selects, strobes and write enables are high, and `busy`, `ack`, `err` and `xcvr_dir_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Bank index to write |
| cfg_wdata | input | 9 | {enable, style, width, waits} |
| req | input | 1 | Request, taken while idle |
| req_waddr | input | 24 | CPU word address |
| req_be | input | 4 | Byte enables, active high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_dma | input | 1 | Request issued by DMA |
| req_beats | input | 2 | Burst words minus one |
| req_sub | input | 1 | 1 = sub-block order, 0 = linear |
| bus_wait_n | input | 1 | External wait / dual-port busy, active low |
| busy | output | 1 | Transaction in progress |
| ack | output | 1 | Data captured or written in this cycle |
| err | output | 1 | Request to an unmapped bank |
| bus_addr | output | 23 | Byte address inside the bank |
| cs_n | output | 6 | Bank chip selects, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 4 | Lane write enables, active low |
| xcvr_oe_n | output | 1 | Transceiver enable, active low |
| xcvr_dir_n | output | 1 | Transceiver direction, low for DMA reads |
| xcvr_dir_en | output | 1 | Drive enable for the direction output |

## Verification
Chip select and strobes change on the edge that takes the request, so they are visible in the same cycle. `ack` is combinational from the last-cycle state and `bus_wait_n`, so it is due W+1 cycles after that edge, or later by the cycles the wait input stretches or restarts the access. `err` is due one cycle after the request edge. The driver pushes for each expected narrow access its address, enables, transceiver levels, the count of select-low cycles, and the number of one-cycle restart gaps. The monitor samples one time unit after each falling edge, counts those cycles, and compares an item at every `ack`, so each result is checked exactly in the cycle it falls due.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
    localparam int NBANK_DEF   = 6;
    localparam int WAIT_W      = 4;
    localparam int WADDR_W_DEF = 24;
    localparam int BANK_AW_DEF = 23;

    typedef enum logic [1:0] {
        STY_MEM       = 2'd0,
        STY_IO_SPLIT  = 2'd1,
        STY_IO_STROBE = 2'd2,
        STY_DUAL      = 2'd3
    } style_e;

    localparam logic [1:0] PW8  = 2'd0;
    localparam logic [1:0] PW16 = 2'd1;
    localparam logic [1:0] PW32 = 2'd2;

    typedef struct packed {
        logic              en;
        style_e            style;
        logic [1:0]        width;
        logic [WAIT_W-1:0] waits;
    } bank_cfg_t;

    localparam int CFG_W = $bits(bank_cfg_t);

    typedef enum logic [1:0] {SQ_IDLE, SQ_ACT, SQ_LAST, SQ_GAP} seq_e;

    // highest slice index for a port width
    function automatic logic [1:0] lanes_m1(input logic [1:0] w);
        case (w)
            PW8:     return 2'd3;
            PW16:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    // byte enables of the current slice moved onto the port's lanes
    function automatic logic [3:0] lane_mask(input logic [1:0] w, input logic [1:0] lane,
                                             input logic [3:0] be);
        case (w)
            PW8:     return {3'b000, be[lane]};
            PW16:    return {2'b00, (lane[0] ? be[3:2] : be[1:0])};
            default: return be;
        endcase
    endfunction

    function automatic logic [3:0] low_nibble(input logic [1:0] w, input logic [1:0] wlo,
                                              input logic [1:0] lane);
        case (w)
            PW8:     return {wlo, lane};
            PW16:    return {wlo, lane[0], 1'b0};
            default: return {wlo, 2'b00};
        endcase
    endfunction

    function automatic logic [1:0] beat_word(input logic sub, input logic [1:0] start,
                                             input logic [1:0] beat);
        return sub ? (start ^ beat) : (start + beat);
    endfunction
endpackage

// File: rtl/mbc_cfg_regs.sv
module mbc_cfg_regs
    import mbc_pkg::*;
#(
    parameter int NBANK = NBANK_DEF,
    localparam int SEL_W = $clog2(NBANK)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [CFG_W-1:0]            wr_data,
    output bank_cfg_t [NBANK-1:0]       cfg
);
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                cfg[g] <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))
                cfg[g] <= bank_cfg_t'(wr_data);
        end
    end
endmodule

// File: rtl/mbc_decode.sv
module mbc_decode
    import mbc_pkg::*;
#(
    parameter int NBANK   = NBANK_DEF,
    parameter int WADDR_W = WADDR_W_DEF,
    parameter int BANK_AW = BANK_AW_DEF,
    localparam int SEL_W  = $clog2(NBANK),
    localparam int OFS_W  = BANK_AW - 2,
    localparam int FLD_W  = WADDR_W - OFS_W
) (
    input  logic [WADDR_W-1:0]      waddr,
    input  bank_cfg_t [NBANK-1:0]   cfg,
    output logic [SEL_W-1:0]        bank,
    output logic                    hit,
    output bank_cfg_t               sel_cfg
);
    logic [FLD_W-1:0] field;
    assign field = waddr[WADDR_W-1:OFS_W];
    assign bank  = SEL_W'(field);

    always_comb begin
        hit     = 1'b0;
        sel_cfg = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (field == FLD_W'(i)) begin
                hit     = cfg[i].en;
                sel_cfg = cfg[i];
            end
        end
    end
endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
    import mbc_pkg::*;
#(
    parameter int NBANK   = NBANK_DEF,
    parameter int WADDR_W = WADDR_W_DEF,
    localparam int SEL_W  = $clog2(NBANK)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic                hit,
    input  logic [SEL_W-1:0]    bank_in,
    input  bank_cfg_t           cfg_in,
    input  logic [WADDR_W-1:0]  waddr_in,
    input  logic [3:0]          be_in,
    input  logic                wr_in,
    input  logic                dma_in,
    input  logic [1:0]          beats_in,
    input  logic                sub_in,
    input  logic                wait_n,
    output seq_e                st,
    output logic [SEL_W-1:0]    bank_q,
    output bank_cfg_t           cfg_q,
    output logic [WADDR_W-1:0]  waddr_q,
    output logic [3:0]          be_q,
    output logic                wr_q,
    output logic                dma_q,
    output logic [1:0]          lane_q,
    output logic [1:0]          wlo,
    output logic                ack,
    output logic                err
);
    logic [1:0]        beats_q, beat_q;
    logic              sub_q;
    logic [WAIT_W-1:0] cnt_q;
    seq_e              reload;

    assign reload = (cfg_q.waits == '0) ? SQ_LAST : SQ_ACT;
    assign ack    = (st == SQ_LAST) && wait_n;
    assign wlo    = beat_word(sub_q, waddr_q[1:0], beat_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SQ_IDLE;  err <= 1'b0;  bank_q <= '0;  cfg_q <= '0;  waddr_q <= '0;
            be_q <= '0;  wr_q <= 1'b0;  dma_q <= 1'b0;  beats_q <= '0;  sub_q <= 1'b0;
            beat_q <= '0;  lane_q <= '0;  cnt_q <= '0;
        end else begin
            err <= 1'b0;
            unique case (st)
                SQ_IDLE: if (req) begin
                    if (hit) begin
                        bank_q <= bank_in;  cfg_q <= cfg_in;  waddr_q <= waddr_in;
                        be_q <= be_in;  wr_q <= wr_in;  dma_q <= dma_in;
                        beats_q <= beats_in;  sub_q <= sub_in;
                        beat_q <= '0;  lane_q <= '0;  cnt_q <= cfg_in.waits;
                        st <= (cfg_in.waits == '0) ? SQ_LAST : SQ_ACT;
                    end else begin
                        err <= 1'b1;
                    end
                end
                SQ_ACT: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == WAIT_W'(1)) st <= SQ_LAST;
                end
                SQ_LAST: if (wait_n) begin
                    if (lane_q == lanes_m1(cfg_q.width)) begin
                        lane_q <= '0;
                        if (beat_q == beats_q) begin
                            st <= SQ_IDLE;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                            cnt_q  <= cfg_q.waits;
                            st     <= reload;
                        end
                    end else begin
                        lane_q <= lane_q + 1'b1;
                        cnt_q  <= cfg_q.waits;
                        st     <= reload;
                    end
                end else if (cfg_q.style == STY_DUAL) begin
                    st <= SQ_GAP;
                end
                SQ_GAP: begin
                    cnt_q <= cfg_q.waits;
                    st    <= reload;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_LAST && !wait_n && cfg_q.style != STY_DUAL)
        |=> (st == SQ_LAST && $stable(lane_q) && $stable(beat_q)));

    assert_dual_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_LAST && !wait_n && cfg_q.style == STY_DUAL) |=> (st == SQ_GAP));

    assert_reject_idle_R2: assert property (@(posedge clk) disable iff (rst)
        err |-> (st == SQ_IDLE));
endmodule

// File: rtl/mem_bus_ctrl.sv
module mem_bus_ctrl
    import mbc_pkg::*;
#(
    parameter int NBANK   = NBANK_DEF,
    parameter int WADDR_W = WADDR_W_DEF,
    parameter int BANK_AW = BANK_AW_DEF,
    localparam int SEL_W  = $clog2(NBANK)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                req,
    input  logic [WADDR_W-1:0]  req_waddr,
    input  logic [3:0]          req_be,
    input  logic                req_wr,
    input  logic                req_dma,
    input  logic [1:0]          req_beats,
    input  logic                req_sub,
    input  logic                bus_wait_n,
    output logic                busy,
    output logic                ack,
    output logic                err,
    output logic [BANK_AW-1:0]  bus_addr,
    output logic [NBANK-1:0]    cs_n,
    output logic                oe_n,
    output logic [3:0]          we_n,
    output logic                xcvr_oe_n,
    output logic                xcvr_dir_n,
    output logic                xcvr_dir_en
);
    bank_cfg_t [NBANK-1:0] cfg;
    bank_cfg_t             sel_cfg, cfg_q;
    logic [SEL_W-1:0]      dec_bank, bank_q;
    logic                  dec_hit, wr_q, dma_q, active;
    logic [WADDR_W-1:0]    waddr_q;
    logic [3:0]            be_q;
    logic [1:0]            lane_q, wlo;
    seq_e                  st;

    mbc_cfg_regs #(.NBANK(NBANK)) u_regs (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_data(cfg_wdata), .cfg(cfg));

    mbc_decode #(.NBANK(NBANK), .WADDR_W(WADDR_W), .BANK_AW(BANK_AW)) u_dec (
        .waddr(req_waddr), .cfg(cfg), .bank(dec_bank), .hit(dec_hit), .sel_cfg(sel_cfg));

    mbc_seq #(.NBANK(NBANK), .WADDR_W(WADDR_W)) u_seq (
        .clk(clk), .rst(rst), .req(req), .hit(dec_hit), .bank_in(dec_bank), .cfg_in(sel_cfg),
        .waddr_in(req_waddr), .be_in(req_be), .wr_in(req_wr), .dma_in(req_dma),
        .beats_in(req_beats), .sub_in(req_sub), .wait_n(bus_wait_n), .st(st),
        .bank_q(bank_q), .cfg_q(cfg_q), .waddr_q(waddr_q), .be_q(be_q), .wr_q(wr_q),
        .dma_q(dma_q), .lane_q(lane_q), .wlo(wlo), .ack(ack), .err(err));

    assign active = (st == SQ_ACT) || (st == SQ_LAST);
    assign busy   = (st != SQ_IDLE);

    for (genvar g = 0; g < NBANK; g++) begin : g_cs
        assign cs_n[g] = !(active && bank_q == SEL_W'(g));
    end

    assign bus_addr    = {waddr_q[BANK_AW-3:2], low_nibble(cfg_q.width, wlo, lane_q)};
    assign oe_n        = !(active && (!wr_q || cfg_q.style == STY_IO_STROBE));
    assign we_n        = (active && wr_q) ? ~lane_mask(cfg_q.width, lane_q, be_q) : 4'hF;
    assign xcvr_oe_n   = !active;
    assign xcvr_dir_en = active && dma_q;
    assign xcvr_dir_n  = !(active && dma_q && !wr_q);

    assert_one_cs_R1: assert property (@(posedge clk) disable iff (rst) $onehot0(~cs_n));

    assert_dir_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !xcvr_dir_en |-> xcvr_dir_n);

    assert_dir_with_oe_R10: assert property (@(posedge clk) disable iff (rst)
        xcvr_dir_en |-> !xcvr_oe_n);

    assert_narrow_we_R7: assert property (@(posedge clk) disable iff (rst)
        (!(&cs_n) && cfg_q.width == PW8) |-> (we_n[3:1] == 3'b111));
endmodule

// File: tb/tb_mem_bus_ctrl.sv
module tb_mem_bus_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_we = 1'b0;  logic [2:0] cfg_sel = '0;  logic [8:0] cfg_wdata = '0;
    logic req = 1'b0;  logic [23:0] req_waddr = '0;  logic [3:0] req_be = '0;
    logic req_wr = 1'b0, req_dma = 1'b0, req_sub = 1'b0, bus_wait_n = 1'b1;
    logic [1:0] req_beats = '0;
    logic busy, ack, err, oe_n, xcvr_oe_n, xcvr_dir_n, xcvr_dir_en;
    logic [22:0] bus_addr;  logic [5:0] cs_n;  logic [3:0] we_n;

    mem_bus_ctrl dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [22:0] addr; logic [5:0] cs_n; logic [3:0] we_n;
        logic oe_n, dir_en, dir_n; int run, gaps;
    } item_t;
    item_t q[$];
    int vectors = 0, fails = 0;
    logic [1:0] bw [6]; logic [1:0] bs [6]; int bwt [6];

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        vectors++;
        if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", msg, act, exp); end
    endtask

    task automatic wcfg(input int b, input bit en, input int sty, input int w, input int wt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(b); cfg_wdata = {en, 2'(sty), 2'(w), 4'(wt)};
        bw[b] = 2'(w); bs[b] = 2'(sty); bwt[b] = wt;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // driver: pushes expected narrow accesses, then drives the request
    task automatic access(input logic [23:0] a, input logic [3:0] be, input bit wr, input bit dma,
                          input int beats, input bit sub, input int k);
        int b, n, w, lastc, g;
        b = int'(a[23:21]); w = bwt[b];
        n = (bw[b] == 2'd0) ? 4 : (bw[b] == 2'd1) ? 2 : 1;
        for (int bt = 0; bt <= beats; bt++) begin
            for (int l = 0; l < n; l++) begin
                item_t it; logic [1:0] wl; logic [3:0] m; logic [3:0] low;
                wl = sub ? (a[1:0] ^ 2'(bt)) : (a[1:0] + 2'(bt));
                if (n == 4) begin low = {wl, 2'(l)}; m = {3'b000, be[l]}; end
                else if (n == 2) begin low = {wl, 1'(l), 1'b0}; m = {2'b00, be[2*l+1], be[2*l]}; end
                else begin low = {wl, 2'b00}; m = be; end
                it.addr = {a[20:2], low};
                it.cs_n = ~(6'b1 << b);
                it.we_n = wr ? ~m : 4'hF;
                it.oe_n = !(!wr || bs[b] == 2'd2);
                it.dir_en = dma; it.dir_n = !(dma && !wr);
                it.run = w + 1; it.gaps = 0;
                if (bt == 0 && l == 0) begin
                    if (bs[b] == 2'd3) begin
                        lastc = w + 1; g = 0;
                        while (k >= lastc) begin lastc = lastc + w + 2; g++; end
                        it.gaps = g;
                    end else if (k + 1 > w + 1) begin
                        it.run = k + 1;
                    end
                end
                q.push_back(it);
            end
        end
        @(negedge clk);
        req = 1'b1; req_waddr = a; req_be = be; req_wr = wr; req_dma = dma;
        req_beats = 2'(beats); req_sub = sub; bus_wait_n = (k == 0);
        @(negedge clk); req = 1'b0;
        if (k > 0) begin repeat (k) @(negedge clk); bus_wait_n = 1'b1; end
        while (busy) @(negedge clk);
    endtask

    task automatic bad_access(input logic [23:0] a);
        @(negedge clk); req = 1'b1; req_waddr = a; req_wr = 1'b0;
        @(negedge clk); req = 1'b0; #1;
        chk(err === 1'b1 && busy === 1'b0 && cs_n === 6'h3F, "R2 err pulse",
            int'({err, busy, cs_n}), int'({1'b1, 1'b0, 6'h3F}));
        @(negedge clk); #1;
        chk(err === 1'b0 && busy === 1'b0, "R2 err one cycle", int'({err, busy}), 0);
    endtask

    // monitor: counts select-low cycles and restart gaps, compares at each ack
    initial begin
        int run = 0, gaps = 0;
        forever begin
            @(negedge clk); #1;
            if (rst) continue;
            if (!(&cs_n)) run++;
            else if (busy) begin gaps++; run = 0; end
            if (ack) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R3 ack with nothing expected", 1, 0);
                end else begin
                    item_t e; bit ok;
                    e = q.pop_front(); ok = 1'b1;
                    if (bus_addr !== e.addr) begin ok = 0;
                        $display("FAIL R6/R8 addr act=%0h exp=%0h", bus_addr, e.addr); end
                    if (cs_n !== e.cs_n) begin ok = 0;
                        $display("FAIL R1 cs_n act=%0h exp=%0h", cs_n, e.cs_n); end
                    if (we_n !== e.we_n) begin ok = 0;
                        $display("FAIL R7 we_n act=%0h exp=%0h", we_n, e.we_n); end
                    if (oe_n !== e.oe_n) begin ok = 0;
                        $display("FAIL R9 oe_n act=%0h exp=%0h", oe_n, e.oe_n); end
                    if (xcvr_oe_n !== 1'b0 || xcvr_dir_en !== e.dir_en || xcvr_dir_n !== e.dir_n) begin
                        ok = 0; $display("FAIL R10 xcvr act=%0h exp=%0h",
                            {xcvr_oe_n, xcvr_dir_en, xcvr_dir_n}, {1'b0, e.dir_en, e.dir_n}); end
                    if (run != e.run) begin ok = 0;
                        $display("FAIL R3/R4 cycles act=%0d exp=%0d", run, e.run); end
                    if (gaps != e.gaps) begin ok = 0;
                        $display("FAIL R5 restarts act=%0d exp=%0d", gaps, e.gaps); end
                    vectors++; if (!ok) fails++;
                end
                run = 0; gaps = 0;
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        fails++; $display("FAIL watchdog act=1 exp=0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk); rst = 1'b0; #1;
        // R11 reset state
        chk(cs_n === 6'h3F && oe_n === 1'b1 && we_n === 4'hF && xcvr_oe_n === 1'b1 &&
            xcvr_dir_en === 1'b0 && busy === 1'b0 && ack === 1'b0 && err === 1'b0,
            "R11 reset outputs", int'({cs_n, oe_n, we_n, busy}), int'({6'h3F, 1'b1, 4'hF, 1'b0}));
        bad_access({3'd0, 21'h000100});     // R11/R2: banks disabled after reset
        wcfg(0, 1, 0, 2, 2);  wcfg(1, 1, 1, 1, 1);  wcfg(2, 1, 2, 0, 0);
        wcfg(3, 1, 3, 2, 2);  wcfg(4, 0, 0, 2, 1);  wcfg(5, 1, 0, 0, 3);
        // R1 R3 R9: plain 32-bit read and write
        access({3'd0, 21'h012345}, 4'hF, 0, 0, 0, 0, 0);
        access({3'd0, 21'h00ABC6}, 4'b1010, 1, 0, 0, 0, 0);
        // R4: wait held past the last cycle stretches, early wait is ignored
        access({3'd0, 21'h000010}, 4'hF, 0, 0, 0, 0, 5);
        access({3'd0, 21'h000020}, 4'hF, 0, 0, 0, 0, 2);
        // R8: linear and sub-block bursts
        access({3'd0, 21'h000402}, 4'hF, 0, 0, 3, 0, 0);
        access({3'd0, 21'h000801}, 4'hF, 1, 0, 3, 1, 0);
        // R6 R7: 16-bit port, split-strobe I/O
        access({3'd1, 21'h001003}, 4'b0110, 1, 0, 0, 0, 0);
        access({3'd1, 21'h001004}, 4'hF, 0, 0, 1, 0, 0);
        // R7 R9 R10: 8-bit single-strobe I/O, DMA read and DMA write
        access({3'd2, 21'h000042}, 4'hF, 0, 1, 0, 0, 0);
        access({3'd2, 21'h000043}, 4'b1001, 1, 1, 0, 0, 0);
        // R5: dual-port busy in the last cycle restarts; earlier busy ignored
        access({3'd3, 21'h0000F0}, 4'hF, 0, 0, 0, 0, 3);
        access({3'd3, 21'h0000F1}, 4'hF, 0, 0, 0, 0, 1);
        // R6 R8: 8-bit memory bank in a sub-block burst
        access({3'd5, 21'h1FFFFE}, 4'b0101, 1, 0, 1, 1, 0);
        // R2: disabled bank and unmapped indices
        bad_access({3'd4, 21'h000000});
        bad_access({3'd6, 21'h000000});
        bad_access({3'd7, 21'h0ABCDE});
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R3 all expected accesses acknowledged", q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule